// File: doc/BRIEF.md
# Post-Transmit Receive Guard Timer

After the reader finishes transmitting, the antenna and demodulator keep ringing for a while. Edges seen during that time would be decoded as noise. This block blanks the receive path for a programmed interval that starts when a transmission ends. While the interval runs, the gated receive output is held at the idle level 0 and a guard-active flag is raised. Outside the interval the raw demodulated input passes straight through.

The interval is set by an 8-bit configuration byte. Bits 6..0 hold a wait count and bit 7 selects the unit in which that count is measured. With bit 7 clear, one unit is a fixed prescale of the carrier clock: 16 clocks by default. With bit 7 set, one unit is half of one data-bit period at the receive baud rate. That rate is chosen by a 3-bit code. The block takes its clock from the 13.56 MHz carrier, so the half-bit lengths come straight from that clock.

Control runs as a two-state machine:
- **IDLE** means no masking is in force.
- **GUARD** means masking is in force.

Its transitions are:
- **START** (IDLE to GUARD) fires on a transmit-done pulse with a nonzero count.
- **RELOAD** (GUARD to GUARD) fires on a new transmit-done pulse with a nonzero count.
- **CANCEL** (GUARD to IDLE) fires on a transmit-done pulse with a zero count.
- **EXPIRE** (GUARD to IDLE) fires when the last unit of the count elapses.

Top module: `rx_guard_timer`

## Requirements
- R1: After reset, `guard_active` is 0 and `config_error` is 0.
- R2: A `tx_done` pulse sampled at a clock edge with a nonzero wait count makes `guard_active` high from that edge on. Without a `tx_done` pulse, `guard_active` never rises.
- R3: With `wait_cfg[7]`=0, `guard_active` stays high for exactly `wait_cfg[6:0]` × 16 clock cycles.
- R4: With `wait_cfg[7]`=1, `guard_active` stays high for exactly `wait_cfg[6:0]` × H clock cycles. H is 64, 32, 16 and 8 for `baud_code` 4, 5, 6 and 7 (106, 212, 424 and 847 kBd).
- R5: A `tx_done` pulse with `wait_cfg[6:0]`=0 produces no masking. If a guard is running, it ends on the next edge.
- R6: A `tx_done` pulse while the guard is active restarts the full interval. The interval is measured from the new pulse and uses the configuration present at that pulse.
- R7: `rx_gated` is 0 while `guard_active` is 1. Otherwise `rx_gated` equals `rx_raw`.
- R8: A reserved `baud_code` (0 to 3) is timed as code 4, that is H = 64. It sets `config_error` from the next edge on, and `config_error` stays set until reset.
- R9: The wait count, unit select and baud code are captured when `tx_done` is sampled. Changes to them while the guard runs do not alter the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.56 MHz carrier-derived clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_cfg | input | 8 | Bit 7 selects the unit (0 = carrier prescale, 1 = half bit); bits 6..0 hold the wait count |
| baud_code | input | 3 | Receive rate code: 4 = 106, 5 = 212, 6 = 424, 7 = 847 kBd; 0 to 3 are reserved |
| tx_done | input | 1 | One-cycle pulse at the end of a transmission |
| rx_raw | input | 1 | Raw demodulated receive input |
| rx_gated | output | 1 | Receive input with masking applied (0 while masked) |
| guard_active | output | 1 | High while the guard interval runs |
| config_error | output | 1 | Sticky flag: a reserved baud code has been seen |

## Verification
The bench builds the block with its default parameters: a carrier prescale of 16, a 106 kBd half-bit of 64 clocks and a 7-bit count. The largest interval is therefore 127 × 64 = 8128 cycles, so every unit length and the full-scale count can be measured exactly in a short run. Each of the four baud codes and one reserved code is measured cycle by cycle. So are the RELOAD and CANCEL transitions, and a configuration change made in the middle of a guard.

// File: rtl/rx_guard_pkg.sv
package rx_guard_pkg;
    typedef enum logic [0:0] {
        GS_IDLE  = 1'b0,
        GS_GUARD = 1'b1
    } guard_state_t;

    function automatic int unsigned bits_for(input int unsigned value);
        int unsigned w;
        w = 1;
        while ((1 << w) <= value) w++;
        return w;
    endfunction
endpackage

// File: rtl/guard_unit_sel.sv
module guard_unit_sel #(
    parameter int unsigned CARRIER_DIV  = 16,
    parameter int unsigned HALF_BIT_MAX = 64,
    parameter int unsigned UNIT_W       = 7
) (
    input  logic              unit_sel,
    input  logic [2:0]        baud_code,
    output logic [UNIT_W-1:0] unit_len,
    output logic              reserved
);
    logic [1:0]        shift_amt;
    logic [UNIT_W-1:0] half_len;

    always_comb begin
        reserved  = ~baud_code[2];
        // codes 4..7 halve the half-bit length per step; reserved codes fall back to the slowest rate
        shift_amt = reserved ? 2'd0 : baud_code[1:0];
        half_len  = UNIT_W'(HALF_BIT_MAX) >> shift_amt;
        unit_len  = unit_sel ? half_len : UNIT_W'(CARRIER_DIV);
    end
endmodule

// File: rtl/guard_prescaler.sv
module guard_prescaler #(
    parameter int unsigned UNIT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [UNIT_W-1:0] unit_len,
    output logic              tick
);
    logic [UNIT_W-1:0] pcnt;
    logic              at_end;

    assign at_end = (pcnt == unit_len - UNIT_W'(1));
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart || !run || at_end) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + UNIT_W'(1);
        end
    end
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import rx_guard_pkg::*;
#(
    parameter int unsigned WAIT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_done,
    input  logic [WAIT_W-1:0] wait_val,
    input  logic              tick,
    output logic              guard_on
);
    guard_state_t      state, state_nx;
    logic [WAIT_W-1:0] remaining;
    logic              wait_zero;
    logic              last_unit;

    assign wait_zero = (wait_val == '0);
    assign last_unit = tick && (remaining == WAIT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GS_IDLE;
        else        state <= state_nx;
    end

    // transitions: START, RELOAD, CANCEL, EXPIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            GS_IDLE: begin
                if (tx_done && !wait_zero) state_nx = GS_GUARD;   // START
            end
            GS_GUARD: begin
                if (tx_done)        state_nx = wait_zero ? GS_IDLE : GS_GUARD; // CANCEL / RELOAD
                else if (last_unit) state_nx = GS_IDLE;                        // EXPIRE
            end
            default: state_nx = GS_IDLE;
        endcase
    end

    // unit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (tx_done) begin
            remaining <= wait_val;
        end else if (state == GS_GUARD && tick) begin
            remaining <= remaining - WAIT_W'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            GS_GUARD: guard_on = 1'b1;
            default:  guard_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_guard_timer.sv
module rx_guard_timer
    import rx_guard_pkg::*;
#(
    parameter int unsigned WAIT_W       = 7,
    parameter int unsigned CARRIER_DIV  = 16,
    parameter int unsigned HALF_BIT_MAX = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W:0]   wait_cfg,
    input  logic [2:0]        baud_code,
    input  logic              tx_done,
    input  logic              rx_raw,
    output logic              rx_gated,
    output logic              guard_active,
    output logic              config_error
);
    localparam int unsigned UNIT_MAX = (CARRIER_DIV > HALF_BIT_MAX) ? CARRIER_DIV : HALF_BIT_MAX;
    localparam int unsigned UNIT_W   = bits_for(UNIT_MAX);

    logic [UNIT_W-1:0] unit_len_cfg;
    logic [UNIT_W-1:0] unit_len_q;
    logic              code_reserved;
    logic              unit_tick;
    logic              guard_on;
    logic              err_q;

    guard_unit_sel #(
        .CARRIER_DIV (CARRIER_DIV),
        .HALF_BIT_MAX(HALF_BIT_MAX),
        .UNIT_W      (UNIT_W)
    ) u_unit_sel (
        .unit_sel (wait_cfg[WAIT_W]),
        .baud_code(baud_code),
        .unit_len (unit_len_cfg),
        .reserved (code_reserved)
    );

    // unit length is frozen at each transmit-done so mid-guard changes are ignored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       unit_len_q <= UNIT_W'(CARRIER_DIV);
        else if (tx_done) unit_len_q <= unit_len_cfg;
    end

    guard_prescaler #(
        .UNIT_W(UNIT_W)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (guard_on),
        .restart (tx_done),
        .unit_len(unit_len_q),
        .tick    (unit_tick)
    );

    guard_fsm #(
        .WAIT_W(WAIT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_done (tx_done),
        .wait_val(wait_cfg[WAIT_W-1:0]),
        .tick    (unit_tick),
        .guard_on(guard_on)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             err_q <= 1'b0;
        else if (code_reserved) err_q <= 1'b1;
    end

    assign guard_active = guard_on;
    assign rx_gated     = guard_on ? 1'b0 : rx_raw;
    assign config_error = err_q;
endmodule

module rx_guard_checker #(
    parameter int unsigned WAIT_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [WAIT_W:0] wait_cfg,
    input logic [2:0]      baud_code,
    input logic            tx_done,
    input logic            rx_raw,
    input logic            rx_gated,
    input logic            guard_active,
    input logic            config_error
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && wait_cfg[WAIT_W-1:0] != '0) |=> guard_active);

    assert_no_spont_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_active && !tx_done) |=> !guard_active);

    assert_zero_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && wait_cfg[WAIT_W-1:0] == '0) |=> !guard_active);

    assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        guard_active |-> !rx_gated);

    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_active |-> (rx_gated == rx_raw));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_code[2] |=> config_error);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |=> config_error);
endmodule

bind rx_guard_timer rx_guard_checker #(.WAIT_W(WAIT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_cfg    (wait_cfg),
    .baud_code   (baud_code),
    .tx_done     (tx_done),
    .rx_raw      (rx_raw),
    .rx_gated    (rx_gated),
    .guard_active(guard_active),
    .config_error(config_error)
);

// File: tb/rx_guard_timer_bench.sv
`timescale 1ns/1ps
module rx_guard_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wait_cfg = 8'h00;
    logic [2:0] baud_code = 3'd4;
    logic       tx_done = 1'b0;
    logic       rx_raw = 1'b0;
    logic       rx_gated;
    logic       guard_active;
    logic       config_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rx_guard_timer u_rx_guard_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_cfg    (wait_cfg),
        .baud_code   (baud_code),
        .tx_done     (tx_done),
        .rx_raw      (rx_raw),
        .rx_gated    (rx_gated),
        .guard_active(guard_active),
        .config_error(config_error)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // drive one transmit-done pulse; returns at the negedge after the sampling edge
    task automatic pulse(input logic [7:0] cfg, input logic [2:0] code);
        @(negedge clk);
        wait_cfg  = cfg;
        baud_code = code;
        tx_done   = 1'b1;
        @(negedge clk);
        tx_done   = 1'b0;
    endtask

    task automatic count_active(output int n);
        n = 0;
        while (guard_active && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(guard_active == 1'b0, "R1 guard after reset", int'(guard_active), 0);
        check(config_error == 1'b0, "R1 error after reset", int'(config_error), 0);
    endtask

    task automatic t_no_spont();
        int seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (guard_active) seen++;
        end
        check(seen == 0, "R2 no guard without tx_done", seen, 0);
    endtask

    task automatic t_carrier();
        int n;
        pulse(8'h05, 3'd4);
        check(guard_active == 1'b1, "R2 guard starts", int'(guard_active), 1);
        count_active(n);
        check(n == 80, "R3 carrier units wait=5", n, 80);
        pulse(8'h7F, 3'd6);
        count_active(n);
        check(n == 2032, "R3 carrier units wait=127", n, 2032);
    endtask

    task automatic t_halfbit();
        int n;
        for (int c = 4; c < 8; c++) begin
            int exp_n;
            exp_n = 3 * (64 >> (c - 4));
            pulse(8'h83, 3'(c));
            count_active(n);
            check(n == exp_n, $sformatf("R4 half-bit code %0d", c), n, exp_n);
        end
        pulse(8'hFF, 3'd4);
        count_active(n);
        check(n == 8128, "R4 half-bit full scale", n, 8128);
    endtask

    task automatic t_zero();
        int n;
        pulse(8'h80, 3'd7);
        check(guard_active == 1'b0, "R5 zero wait no mask", int'(guard_active), 0);
        pulse(8'h0A, 3'd4);
        repeat (10) @(negedge clk);
        pulse(8'h00, 3'd4);
        check(guard_active == 1'b0, "R5 zero wait cancels guard", int'(guard_active), 0);
        count_active(n);
    endtask

    task automatic t_reload();
        int n;
        pulse(8'h04, 3'd4);
        repeat (30) @(negedge clk);
        check(guard_active == 1'b1, "R6 still active before reload", int'(guard_active), 1);
        pulse(8'h86, 3'd7);
        count_active(n);
        check(n == 48, "R6 reload with new config", n, 48);
    endtask

    task automatic t_latch();
        int n;
        pulse(8'h05, 3'd4);
        wait_cfg  = 8'hFF;
        baud_code = 3'd7;
        count_active(n);
        check(n == 80, "R9 config captured at start", n, 80);
    endtask

    task automatic t_gate();
        int n;
        rx_raw = 1'b1;
        @(negedge clk);
        check(rx_gated == 1'b1, "R7 pass-through idle high", int'(rx_gated), 1);
        pulse(8'h02, 3'd4);
        check(rx_gated == 1'b0, "R7 masked during guard", int'(rx_gated), 0);
        count_active(n);
        check(rx_gated == 1'b1, "R7 pass-through after guard", int'(rx_gated), 1);
        rx_raw = 1'b0;
        @(negedge clk);
        check(rx_gated == 1'b0, "R7 pass-through idle low", int'(rx_gated), 0);
    endtask

    task automatic t_reserved();
        int n;
        check(config_error == 1'b0, "R8 no error before reserved code", int'(config_error), 0);
        pulse(8'h82, 3'd2);
        check(config_error == 1'b1, "R8 error on reserved code", int'(config_error), 1);
        count_active(n);
        check(n == 128, "R8 reserved timed as code 4", n, 128);
        baud_code = 3'd5;
        repeat (5) @(negedge clk);
        check(config_error == 1'b1, "R8 error sticky", int'(config_error), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_spont();
        t_carrier();
        t_halfbit();
        t_zero();
        t_reload();
        t_latch();
        t_gate();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule